// File: doc/BRIEF.md
# Sleep-Wake ADC Serial Port Controller

This block is the device-side digital controller of a multiplexed delta-sigma converter. It runs one conversion at a time. When a conversion finishes it either sleeps or, if the host already holds chip select low, goes straight to readout. A single serial output carries two kinds of information. While a conversion runs it is a busy flag. Once the conversion is done it carries the 32-bit result. While the result is being read out, the host shifts in an 8-bit word that sets the channel, the oversampling code and the double-speed bit for the next conversion.

The analog parts of the converter are not part of this block. A cycle counter stands in for the conversion engine. Its run length is a base count times the oversampling ratio, halved in double-speed mode. At the end of the run the block latches the parallel result word. The chip-select, serial-clock and serial-data pins are treated as synchronous to `clk` and are registered once on entry. The serial clock idles low and must run several times slower than `clk`.

Top module: `adc_sp_ctrl`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is low one clock later, so the serial output is released. While `cs_n` is low, `sdo_oe` is high one clock later.
- R2: With `cs_n` low, `sdo` is 1 for the whole of a conversion. From the end of the conversion until the first falling serial-clock edge, `sdo` is 0.
- R3: A conversion lasts exactly `CONV_BASE * 2^(6+osr)` clocks, halved when the double-speed bit is 1.
- R4: A conversion that ends with `cs_n` high leaves the block asleep. While `cs_n` stays high, serial-clock activity has no effect and no new conversion starts. Pulling `cs_n` low shows status 0.
- R5: During readout, falling serial-clock edge k (k = 1..32) puts result bit 32-k on `sdo`, MSB first. The result is the `conv_result` value captured in the cycle the conversion ended.
- R6: The first 8 rising serial-clock edges of a readout sample `sdi` MSB first as [7] enable, [6:4] channel, [3:1] oversampling code, [0] double-speed. With enable = 1, these values appear on `chan_sel`, `osr_sel` and `speed_2x` when the next conversion starts.
- R7: A complete 8-bit word with enable = 0 leaves all three settings unchanged.
- R8: If fewer than 8 bits arrive before a transfer ends, all three settings stay unchanged.
- R9: A rising `cs_n` during readout aborts the transfer and starts a new conversion two clocks after the edge reaches the pin.
- R10: The 33rd falling serial-clock edge of a readout completes the transfer and starts a new conversion.
- R11: After reset, the channel is 0, the oversampling code is 2 (ratio 256), double speed is off, and a conversion is running.
- R12: `chan_sel`, `osr_sel` and `speed_2x` change only in the cycle a conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select / wake |
| sck | input | 1 | Serial clock from host, idle low |
| sdi | input | 1 | Serial configuration data from host |
| conv_result | input | RES_W | Result word from the conversion stub |
| sdo | output | 1 | Serial status/data output value |
| sdo_oe | output | 1 | Output enable for the three-state pad |
| chan_sel | output | CHAN_W | Channel for the running conversion |
| osr_sel | output | OSR_W | Oversampling code for the running conversion |
| speed_2x | output | 1 | Double-speed mode for the running conversion |

## Verification
- `sdo_oe` follows `cs_n` one clock later.
- A chip-select or serial-clock edge changes state two clocks after the input moves: one clock to register the pin and one to act on the edge.
- The busy window then lasts exactly the conversion length.

The bench drives inputs on falling clock edges. It holds each serial-clock phase for three clocks and samples `sdo` at the end of that phase, after the two-clock latency. The conversion length is measured by counting falling-edge samples of a high `sdo`, starting at the sample right after `cs_n` is pulled back low. The count is compared with the formula exactly.

// File: rtl/adc_sp_pkg.sv
// Package: shared types for the sleep-wake ADC serial port controller.
// Assumes nothing beyond IEEE 1800-2017.
package adc_sp_pkg;

    // Controller phase: converting, asleep with result held, or reading out.
    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_XFER  = 2'd2
    } sp_state_e;

endpackage

// File: rtl/adc_sp_pin_sync.sv
// Module: registers a group of host pins once and keeps the previous sample,
// so the parent can form edge pulses. Assumes the pins already meet clk timing.
module adc_sp_pin_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_d_o
);

    // Capture the current and previous pin samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o   <= RST_VAL;
            q_d_o <= RST_VAL;
        end else begin
            q_o   <= pin_i;
            q_d_o <= q_o;
        end
    end

endmodule

// File: rtl/adc_sp_conv_timer.sv
// Module: stand-in for the conversion engine. It counts clocks while the
// controller converts and pulses done in the last cycle. The run length is
// CONV_BASE * 2^(OSR_LOG2_MIN + osr), halved in double-speed mode.
// Assumes osr and x2 stay stable during a run.
module adc_sp_conv_timer #(
    parameter int CONV_BASE    = 1,
    parameter int OSR_W        = 3,
    parameter int OSR_LOG2_MIN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [OSR_W-1:0] osr,
    input  logic             x2,
    output logic             done
);

    localparam int MAX_LEN = CONV_BASE << (OSR_LOG2_MIN + (1 << OSR_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] target;

    // Work out the run length from the active settings.
    always_comb begin
        base_len = CNT_W'(CONV_BASE) << (OSR_LOG2_MIN + int'(osr));
        target   = x2 ? (base_len >> 1) : base_len;
    end

    // Count clocks of the running conversion; a start clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign done = run && (cnt == target - CNT_W'(1));

endmodule

// File: rtl/adc_sp_cfg_shift.sv
// Module: collects the configuration word from sdi, MSB first. It stops after
// CFG_W bits and flags when the word is complete. Assumes the parent gates
// sample to rising serial-clock edges during readout.
module adc_sp_cfg_shift #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             bit_i,
    output logic [CFG_W-1:0] word_o,
    output logic             full_o
);

    localparam int CNT_W = $clog2(CFG_W + 1);

    logic [CNT_W-1:0] cnt;

    // Shift in one bit per sample until the word is full.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_o <= '0;
            cnt    <= '0;
        end else if (sample && !full_o) begin
            word_o <= {word_o[CFG_W-2:0], bit_i};
            cnt    <= cnt + CNT_W'(1);
        end
    end

    assign full_o = (cnt == CNT_W'(CFG_W));

endmodule

// File: rtl/adc_sp_out_shift.sv
// Module: holds the latched result and moves it onto the output bit, MSB
// first, one bit per shift. After a load the output bit is 0, which is the
// "conversion finished" status. last flags the shift after all RES_W bits.
module adc_sp_out_shift #(
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] data,
    input  logic             shift_en,
    output logic             bit_o,
    output logic             last
);

    localparam int CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] sh;
    logic [CNT_W-1:0] fcnt;

    // Load the result on conversion end; present the next bit on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            fcnt  <= '0;
            bit_o <= 1'b0;
        end else if (load) begin
            sh    <= data;
            fcnt  <= '0;
            bit_o <= 1'b0;
        end else if (shift_en && fcnt != CNT_W'(RES_W)) begin
            bit_o <= sh[RES_W-1];
            sh    <= {sh[RES_W-2:0], 1'b0};
            fcnt  <= fcnt + CNT_W'(1);
        end
    end

    assign last = shift_en && (fcnt == CNT_W'(RES_W));

endmodule

// File: rtl/adc_sp_ctrl.sv
// Module: top of the sleep-wake ADC serial port controller. It sequences
// conversion, sleep and readout; drives status or result data on sdo; captures
// the next-conversion settings; and handles aborts by chip select.
// Assumes cs_n, sck and sdi are synchronous to clk and that sck is slow.
module adc_sp_ctrl #(
    parameter int RES_W        = 32,
    parameter int CHAN_W       = 3,
    parameter int OSR_W        = 3,
    parameter int OSR_LOG2_MIN = 6,
    parameter int CONV_BASE    = 1,
    parameter int DEF_OSR      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [RES_W-1:0]  conv_result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CHAN_W-1:0] chan_sel,
    output logic [OSR_W-1:0]  osr_sel,
    output logic              speed_2x
);

    import adc_sp_pkg::*;

    localparam int CFG_W   = 2 + CHAN_W + OSR_W;
    localparam int EN_POS  = CFG_W - 1;
    localparam int CH_LSB  = OSR_W + 1;
    localparam int OSR_LSB = 1;

    sp_state_e        state;
    logic [1:0]       pin_q;
    logic [1:0]       pin_d;
    logic             cs_q;
    logic             cs_rise;
    logic             sck_rise;
    logic             sck_fall;
    logic             sdi_q;
    logic             conv_done;
    logic             conv_start;
    logic             out_last;
    logic             out_bit;
    logic [CFG_W-1:0] cfg_word;
    logic             cfg_full;
    logic             cfg_apply;

    // Register chip select (bit 1) and serial clock (bit 0).
    adc_sp_pin_sync #(
        .W       (2),
        .RST_VAL (2'b10)
    ) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cs_n, sck}),
        .q_o   (pin_q),
        .q_d_o (pin_d)
    );

    // Register the serial data input alongside the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sdi_q <= 1'b0;
        else        sdi_q <= sdi;
    end

    // Form edge pulses from the registered pins.
    always_comb begin
        cs_q     = pin_q[1];
        cs_rise  = pin_q[1] & ~pin_d[1];
        sck_rise = pin_q[0] & ~pin_d[0];
        sck_fall = ~pin_q[0] & pin_d[0];
    end

    // A new conversion starts on an abort or on the end of a full readout.
    assign conv_start = (state == ST_XFER) && (cs_rise || out_last);
    assign cfg_apply  = conv_start && cfg_full && cfg_word[EN_POS];

    // Phase sequencing: convert, then sleep or read out, then convert again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CONV;
        end else begin
            unique case (state)
                ST_CONV:  if (conv_done) state <= cs_q ? ST_SLEEP : ST_XFER;
                ST_SLEEP: if (!cs_q)     state <= ST_XFER;
                ST_XFER:  if (conv_start) state <= ST_CONV;
                default:  state <= ST_CONV;
            endcase
        end
    end

    // Conversion stand-in timed from the active settings.
    adc_sp_conv_timer #(
        .CONV_BASE    (CONV_BASE),
        .OSR_W        (OSR_W),
        .OSR_LOG2_MIN (OSR_LOG2_MIN)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .run   (state == ST_CONV),
        .osr   (osr_sel),
        .x2    (speed_2x),
        .done  (conv_done)
    );

    // Collect next-conversion settings on rising serial-clock edges.
    adc_sp_cfg_shift #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (conv_start),
        .sample ((state == ST_XFER) && !cs_q && sck_rise),
        .bit_i  (sdi_q),
        .word_o (cfg_word),
        .full_o (cfg_full)
    );

    // Result latch and output shifter, advanced on falling serial-clock edges.
    adc_sp_out_shift #(
        .RES_W (RES_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_done),
        .data     (conv_result),
        .shift_en ((state == ST_XFER) && !cs_q && !cs_rise && sck_fall),
        .bit_o    (out_bit),
        .last     (out_last)
    );

    // Settings in force: defaults at reset, updated only at conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel <= '0;
            osr_sel  <= OSR_W'(DEF_OSR);
            speed_2x <= 1'b0;
        end else if (cfg_apply) begin
            chan_sel <= cfg_word[CH_LSB +: CHAN_W];
            osr_sel  <= cfg_word[OSR_LSB +: OSR_W];
            speed_2x <= cfg_word[0];
        end
    end

    // Pad drive: busy flag while converting, status or data otherwise.
    assign sdo_oe = ~cs_q;
    assign sdo    = sdo_oe & ((state == ST_CONV) ? 1'b1 : out_bit);

endmodule

// File: rtl/adc_sp_ctrl_chk.sv
// Module: assertion checker for adc_sp_ctrl, attached by bind below.
module adc_sp_ctrl_chk #(
    parameter int CHAN_W = 3,
    parameter int OSR_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  cs_q,
    input logic                  cs_rise,
    input logic                  sdo,
    input logic                  sdo_oe,
    input adc_sp_pkg::sp_state_e state,
    input logic                  conv_start,
    input logic                  conv_done,
    input logic [CHAN_W-1:0]     chan_sel,
    input logic [OSR_W-1:0]      osr_sel,
    input logic                  speed_2x
);

    import adc_sp_pkg::*;

    // R1: a high chip select releases the pad one clock later.
    p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo_oe);

    // R2: busy flag high throughout a conversion while the pad is driven.
    p_busy_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && sdo_oe) |-> sdo);

    // R2: status goes low right after a conversion ends.
    p_status_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !sdo);

    // R3: the timer finishes only during a conversion.
    p_done_in_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> state == ST_CONV);

    // R4: sleep holds while chip select stays high.
    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && cs_q) |=> state == ST_SLEEP);

    // R9: chip select rising during readout starts a conversion.
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && cs_rise) |=> state == ST_CONV);

    // R12: settings hold unless a conversion starts.
    p_settings_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable({chan_sel, osr_sel, speed_2x}));

endmodule

bind adc_sp_ctrl adc_sp_ctrl_chk #(
    .CHAN_W (CHAN_W),
    .OSR_W  (OSR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cs_q       (cs_q),
    .cs_rise    (cs_rise),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .state      (state),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .chan_sel   (chan_sel),
    .osr_sel    (osr_sel),
    .speed_2x   (speed_2x)
);

// File: tb/test_adc_sp_ctrl.sv
// Bench: directed corner cases plus seeded random readouts, checked against
// a model of the settings and of the conversion length.
module test_adc_sp_ctrl;

    localparam int BASE = 1;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [31:0] conv_result = '0;
    logic        sdo;
    logic        sdo_oe;
    logic [2:0]  chan_sel;
    logic [2:0]  osr_sel;
    logic        speed_2x;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  m_chan;
    logic [2:0]  m_osr;
    logic        m_x2;
    logic [31:0] cur_res;
    logic [31:0] nxt_res;

    always #2.5 clk = ~clk;

    adc_sp_ctrl #(.CONV_BASE(BASE)) i_adc_sp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .sdi         (sdi),
        .conv_result (conv_result),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .chan_sel    (chan_sel),
        .osr_sel     (osr_sel),
        .speed_2x    (speed_2x)
    );

    function automatic int conv_len(logic [2:0] osr, logic x2);
        int n = BASE << (6 + int'(osr));
        return x2 ? n / 2 : n;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_settings(string req);
        chk({chan_sel, osr_sel, speed_2x} == {m_chan, m_osr, m_x2}, req,
            {chan_sel, osr_sel, speed_2x}, {m_chan, m_osr, m_x2});
    endtask

    // Count busy samples until status drops; returns the count.
    task automatic busy_count(output int n);
        n = 0;
        for (int g = 0; g < 20000; g++) begin
            tick(1);
            if (sdo_oe && sdo) n++;
            else break;
        end
    endtask

    // One readout of nclk serial clocks; checks each data bit (R5).
    task automatic xfer(logic [7:0] cfg, int nclk);
        chk(sdo_oe && !sdo, "R2 status low before readout", sdo, 0);
        for (int i = 1; i <= nclk; i++) begin
            sdi = (i <= 8) ? cfg[8-i] : 1'($urandom);
            tick(1);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
            tick(HALF);
            if (i <= 32)
                chk(sdo == cur_res[32-i], "R5 data bit", sdo, cur_res[32-i]);
            if (i == 8) chk_settings("R12 settings held mid-readout");
        end
        if (nclk >= 8 && cfg[7]) begin
            m_chan = cfg[6:4];
            m_osr  = cfg[3:1];
            m_x2   = cfg[0];
        end
    endtask

    // Abort readout by chip select and measure the new conversion (R9, R3).
    task automatic abort_and_time(string req);
        int n;
        cs_n = 1'b1;
        tick(1);
        cs_n = 1'b0;
        busy_count(n);
        chk(n == conv_len(m_osr, m_x2), req, n, conv_len(m_osr, m_x2));
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_1234));
        conv_result = 32'hA5C3_0F96;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        m_chan = 3'd0; m_osr = 3'd2; m_x2 = 1'b0;
        chk_settings("R11 reset settings");
        chk(!sdo_oe, "R1 pad released with cs high", sdo_oe, 0);

        // Default conversion ends with cs high: sleep.
        tick(400);
        conv_result = 32'h1234_5678;
        for (int k = 0; k < 4; k++) begin
            sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        chk(!sdo_oe, "R1 pad released while asleep", sdo_oe, 0);
        cs_n = 1'b0;
        tick(3);
        chk(sdo_oe && !sdo, "R4 wake shows status low", sdo, 0);
        cur_res = 32'hA5C3_0F96;

        // Full readout with new settings, completes on 33rd fall.
        nxt_res = 32'hDEAD_BEEF;
        conv_result = nxt_res;
        xfer({1'b1, 3'd5, 3'd0, 1'b1}, 33);
        chk(sdo_oe && sdo, "R10 conversion after 33rd fall", sdo, 1);
        chk_settings("R6 new settings applied");
        busy_count(n);
        cur_res = nxt_res;

        // Abort with no clocks: exact timing, settings kept.
        nxt_res = 32'h0F0F_3C3C;
        conv_result = nxt_res;
        abort_and_time("R9 R3 abort timing 2x osr0");
        chk_settings("R8 no bits keeps settings");
        cur_res = nxt_res;

        // Enable bit low: settings unchanged.
        xfer({1'b0, 3'd2, 3'd1, 1'b0}, 10);
        abort_and_time("R9 abort after 10 clocks");
        chk_settings("R7 enable low keeps settings");

        // Seven bits only: settings unchanged.
        xfer({1'b1, 3'd7, 3'd1, 1'b0}, 7);
        abort_and_time("R9 abort after 7 clocks");
        chk_settings("R8 partial word keeps settings");

        // Random readouts.
        for (int it = 0; it < 20; it++) begin
            logic [7:0] cfg;
            int nclk;
            cfg = 8'($urandom);
            cfg[3:1] = 3'($urandom_range(2, 0));
            nclk = $urandom_range(33, 0);
            nxt_res = $urandom;
            conv_result = nxt_res;
            xfer(cfg, nclk);
            if (nclk == 33) begin
                chk(sdo_oe && sdo, "R10 random completion", sdo, 1);
                busy_count(n);
            end else begin
                abort_and_time("R3 random abort timing");
            end
            chk_settings("R6 random settings");
            cur_res = nxt_res;
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule